// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status registers behind a simple two-phase peripheral bus (setup phase, then access phase with `psel` and `penable` high). It decodes a 4 KB window and presents the state a system controller needs: a secure-debug status word that software alters only through dedicated set and clear aliases, a reset-cause word, a reset-cause mask, a retention word that survives ordinary resets, a boot vector base, a core-hold word and a wake-logic control word. It also serves a fixed set of identification bytes at the top of the window.

A write that sets the request bit of the software-reset offset produces a single-cycle `rst_req` pulse for the reset controller. Any access to an offset with no register behind it completes normally, reads zero and raises a one-cycle `bad_access` flag. Byte and halfword accesses use the little-endian lanes selected by the low address bits. On a write, the unselected lanes are zero, and the full word is written.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset the reset-cause word (0x100) reads 0x00000001 and the boot vector base (0x110) reads 0x10000000. Secure-debug status (0x000), reset mask (0x104), retention (0x10C), core hold (0x118) and wake control (0x120) read 0.
- R2: The words at 0x100, 0x104, 0x10C, 0x110, 0x118 and 0x120 are read/write storage. Each returns the last value written to it.
- R3: A write to 0x004 ORs the written data into the secure-debug status word.
- R4: A write to 0x008 clears every status bit whose written bit is 1. A write to 0x000 leaves the status unchanged.
- R5: Offsets 0x004, 0x008 and 0x108 are write-only and read 0. Offset 0x11C always reads 0 and ignores writes.
- R6: `rst_req` is high for exactly the one cycle after the access-phase clock edge of a write to 0x108 whose padded data has bit 9 set. It stays low for any other access.
- R7: The word offsets 0xFD0 through 0xFFC return, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: Writes to the identification offsets have no effect on their read values.
- R9: `psize` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A byte access uses lane `paddr[1:0]` and a halfword access uses lanes {2·`paddr[1]`, 2·`paddr[1]`+1`}. A word access uses all four lanes. Reads return zero in unselected lanes. Writes store zero in unselected lanes.
- R10: An access to any other word offset reads 0 and changes no register. `bad_access` is high for the one cycle after its access-phase edge. Mapped accesses leave it low.
- R11: `rst_n` low clears every register except retention. `por_n` low clears all registers, retention included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low; clears everything |
| rst_n | input | 1 | System reset, async, active low; spares retention |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the window |
| psize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| pwdata | input | 32 | Write data on natural byte lanes |
| prdata | output | 32 | Read data, valid in the access phase |
| rst_req | output | 1 | One-cycle software reset request |
| bad_access | output | 1 | One-cycle flag for an unmapped access |

## Verification
On every cycle, the assertions check three things. They confirm that the set and clear aliases have their effect on the status word and that nothing else moves it. They confirm that the retention word changes only when written, and that write-only and reserved offsets read zero. They also confirm that `rst_req` and `bad_access` only follow an access phase. Only the bench scenarios can show the remaining behaviours. These are the exact reset values, and that each stored word returns its data with the correct lane masking. They also include the identification values, the absence of side effects from writes to the ignored and unmapped offsets across the whole window, the gating of the request bit by the byte lanes, and the split between the two reset inputs.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int LANES  = WORD_W / 8;
  localparam int ID_CNT = 12;
  localparam int REQ_BIT = 9;
  localparam logic [ADDR_W-3:0] ID_BASE_W = 10'h3F4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DBG_STAT, SEL_DBG_SET, SEL_DBG_CLR,
    SEL_CAUSE, SEL_CMASK, SEL_SWRST, SEL_RETAIN,
    SEL_VBASE, SEL_HOLD, SEL_BUSRSV, SEL_WAKE, SEL_IDENT
  } reg_sel_e;

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                 input logic [1:0] low);
    logic [LANES-1:0] m;
    case (size)
      2'd0:    m = 4'b0001 << low;
      2'd1:    m = low[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] lane_expand(input logic [LANES-1:0] m);
    logic [WORD_W-1:0] e;
    for (int i = 0; i < LANES; i++) e[i*8 +: 8] = {8{m[i]}};
    return e;
  endfunction

  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    case (idx)
      4'd0: return 8'h04;
      4'd4: return 8'h54;
      4'd5: return 8'hB8;
      4'd6: return 8'h0B;
      4'd8: return 8'h0D;
      4'd9: return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [3:0]        id_idx
);
  logic [ADDR_W-3:0] waddr;
  logic [ADDR_W-3:0] id_off;
  assign waddr  = addr[ADDR_W-1:2];
  assign id_off = waddr - ID_BASE_W;
  assign id_idx = id_off[3:0];

  always_comb begin
    case (waddr)
      10'h000: sel = SEL_DBG_STAT;
      10'h001: sel = SEL_DBG_SET;
      10'h002: sel = SEL_DBG_CLR;
      10'h040: sel = SEL_CAUSE;
      10'h041: sel = SEL_CMASK;
      10'h042: sel = SEL_SWRST;
      10'h043: sel = SEL_RETAIN;
      10'h044: sel = SEL_VBASE;
      10'h046: sel = SEL_HOLD;
      10'h047: sel = SEL_BUSRSV;
      10'h048: sel = SEL_WAKE;
      default: sel = (waddr >= ID_BASE_W) ? SEL_IDENT : SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] CAUSE_RST = 32'h0000_0001,
  parameter logic [WORD_W-1:0] VBASE_RST = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dbg_stat,
  output logic [WORD_W-1:0] cause,
  output logic [WORD_W-1:0] cmask,
  output logic [WORD_W-1:0] retain,
  output logic [WORD_W-1:0] vbase,
  output logic [WORD_W-1:0] hold,
  output logic [WORD_W-1:0] wake
);
  logic set_hit, clr_hit, ret_hit;
  assign set_hit = wr_en && (sel == SEL_DBG_SET);
  assign clr_hit = wr_en && (sel == SEL_DBG_CLR);
  assign ret_hit = wr_en && (sel == SEL_RETAIN);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      dbg_stat <= '0;
      cause    <= CAUSE_RST;
      cmask    <= '0;
      vbase    <= VBASE_RST;
      hold     <= '0;
      wake     <= '0;
    end else begin
      if (set_hit) dbg_stat <= dbg_stat | wdata;
      else if (clr_hit) dbg_stat <= dbg_stat & ~wdata;
      if (wr_en) begin
        case (sel)
          SEL_CAUSE: cause <= wdata;
          SEL_CMASK: cmask <= wdata;
          SEL_VBASE: vbase <= wdata;
          SEL_HOLD:  hold  <= wdata;
          SEL_WAKE:  wake  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) retain <= '0;
    else if (ret_hit) retain <= wdata;
  end

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $past(set_hit) |-> ((dbg_stat & $past(wdata)) == $past(wdata)));
  // R4
  clr_alias_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $past(clr_hit) |-> ((dbg_stat & $past(wdata)) == '0));
  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(set_hit || clr_hit) |=> $stable(dbg_stat));
  // R11
  retain_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ret_hit |=> $stable(retain));
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] CAUSE_RST = 32'h0000_0001,
  parameter logic [WORD_W-1:0] VBASE_RST = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [1:0]        psize,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic              rst_req,
  output logic              bad_access
);
  logic sys_rst_n;
  assign sys_rst_n = rst_n & por_n;

  reg_sel_e          sel;
  logic [3:0]        id_idx;
  logic              acc, wr_en, rd_en;
  logic [WORD_W-1:0] lane_bits, wdata_pad, rword;
  logic [WORD_W-1:0] dbg_stat, cause, cmask, retain, vbase, hold, wake;
  logic              req_ev, bad_ev;

  sysctl_decode u_dec (.addr(paddr), .sel(sel), .id_idx(id_idx));

  assign acc       = psel && penable;
  assign wr_en     = acc && pwrite;
  assign rd_en     = acc && !pwrite;
  assign lane_bits = lane_expand(lane_mask(psize, paddr[1:0]));
  assign wdata_pad = pwdata & lane_bits;

  sysctl_store #(.CAUSE_RST(CAUSE_RST), .VBASE_RST(VBASE_RST)) u_store (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n), .wr_en(wr_en),
    .sel(sel), .wdata(wdata_pad), .dbg_stat(dbg_stat), .cause(cause),
    .cmask(cmask), .retain(retain), .vbase(vbase), .hold(hold), .wake(wake)
  );

  always_comb begin
    case (sel)
      SEL_DBG_STAT: rword = dbg_stat;
      SEL_CAUSE:    rword = cause;
      SEL_CMASK:    rword = cmask;
      SEL_RETAIN:   rword = retain;
      SEL_VBASE:    rword = vbase;
      SEL_HOLD:     rword = hold;
      SEL_WAKE:     rword = wake;
      SEL_IDENT:    rword = {24'h0, ident_byte(id_idx)};
      default:      rword = '0;
    endcase
  end

  assign prdata = rd_en ? (rword & lane_bits) : '0;

  assign req_ev = wr_en && (sel == SEL_SWRST) && wdata_pad[REQ_BIT];
  assign bad_ev = acc && (sel == SEL_NONE);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rst_req    <= 1'b0;
      bad_access <= 1'b0;
    end else begin
      rst_req    <= req_ev;
      bad_access <= bad_ev;
    end
  end

  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_req |-> $past(psel && penable && pwrite));
  // R10
  bad_source_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    bad_access |-> $past(psel && penable));
  // R5
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rd_en && (sel == SEL_DBG_SET || sel == SEL_DBG_CLR ||
               sel == SEL_SWRST || sel == SEL_BUSRSV)) |-> (prdata == '0));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rd_en && sel == SEL_NONE) |-> (prdata == '0));
endmodule

// File: tb/test_sys_ctrl_regs.sv
`timescale 1ns/1ps
module test_sys_ctrl_regs;
  logic clk = 0, por_n = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [1:0] psize = 2;
  logic [31:0] pwdata = 0, prdata;
  logic rst_req, bad_access;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sys_ctrl_regs i_sys_ctrl_regs (.clk(clk), .por_n(por_n), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .psize(psize), .pwdata(pwdata), .prdata(prdata), .rst_req(rst_req),
    .bad_access(bad_access));

  // model state
  logic [31:0] m_stat, m_cause, m_cmask, m_ret, m_vbase, m_hold, m_wake;
  logic [7:0] id_tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                              8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] sz, input logic [11:0] a);
    logic [31:0] m = 0;
    for (int b = 0; b < 4; b++) begin
      logic on;
      if (sz >= 2) on = 1;
      else if (sz == 1) on = ((b / 2) == a[1]);
      else on = (b == a[1:0]);
      if (on) m = m | (32'hFF << (8 * b));
    end
    return m;
  endfunction

  function automatic bit is_mapped(input logic [11:0] a);
    int w = a / 4;
    return (w <= 2) || (w >= 'h40 && w <= 'h48 && w != 'h45) || (w >= 'h3F4);
  endfunction

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    int w = a / 4;
    if (w >= 'h3F4) return {24'h0, id_tab[w - 'h3F4]};
    case (w)
      0: return m_stat;
      'h40: return m_cause;
      'h41: return m_cmask;
      'h43: return m_ret;
      'h44: return m_vbase;
      'h46: return m_hold;
      'h48: return m_wake;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a / 4)
      1: m_stat = m_stat | d;
      2: m_stat = m_stat & ~d;
      'h40: m_cause = d;
      'h41: m_cmask = d;
      'h43: m_ret = d;
      'h44: m_vbase = d;
      'h46: m_hold = d;
      'h48: m_wake = d;
      default: ;
    endcase
  endtask

  task automatic model_reset(input bit por);
    m_stat = 0; m_cause = 1; m_cmask = 0; m_vbase = 32'h1000_0000;
    m_hold = 0; m_wake = 0;
    if (por) m_ret = 0;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic bad, output logic req);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; psize = sz; pwdata = d;
    @(negedge clk);
    penable = 1;
    #2 rd = prdata;
    @(negedge clk);
    bad = bad_access; req = rst_req;
    psel = 0; penable = 0; pwrite = 0;
    if (wr) model_write(a, d & mask_of(sz, a));
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [1:0] sz);
    logic [31:0] r; logic b, q;
    access(0, a, sz, 0, r, b, q);
    chk(req, r, exp_word(a) & mask_of(sz, a));
    chk("R10 flag", {31'b0, b}, {31'b0, !is_mapped(a)});
  endtask

  task automatic wr_op(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                       output logic bad, output logic req);
    logic [31:0] r;
    access(1, a, sz, d, r, bad, req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic b, q;
  logic [11:0] regs_rw [6] = '{12'h100, 12'h104, 12'h10C, 12'h110, 12'h118, 12'h120};
  initial begin
    model_reset(1);
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    // R1 reset values, plus R5 R7 R10 across the whole window
    for (int a = 0; a < 4096; a += 4) rd_chk("R1/R7 sweep", a[11:0], 2);
    chk("R6 idle", {31'b0, rst_req}, 0);
    // R2 storage
    foreach (regs_rw[i]) begin
      wr_op(regs_rw[i], 2, 32'hA5C3_0000 + i, b, q);
      chk("R10 mapped write", {31'b0, b}, 0);
      rd_chk("R2 readback", regs_rw[i], 2);
    end
    // R3 set alias, R4 clear alias and status read-only
    wr_op(12'h004, 2, 32'h0000_00F0, b, q); rd_chk("R3 set", 12'h000, 2);
    wr_op(12'h004, 2, 32'h8000_0003, b, q); rd_chk("R3 set or", 12'h000, 2);
    wr_op(12'h008, 2, 32'h0000_0031, b, q); rd_chk("R4 clear", 12'h000, 2);
    wr_op(12'h000, 2, 32'hFFFF_FFFF, b, q); rd_chk("R4 stat ro", 12'h000, 2);
    // R5 write-only and reserved
    rd_chk("R5 set rd", 12'h004, 2);
    rd_chk("R5 clr rd", 12'h008, 2);
    wr_op(12'h11C, 2, 32'hFFFF_FFFF, b, q); rd_chk("R5 buswait", 12'h11C, 2);
    // R6 reset request
    wr_op(12'h108, 2, 32'h0000_0200, b, q);
    chk("R6 pulse", {31'b0, q}, 1);
    @(negedge clk); chk("R6 one cycle", {31'b0, rst_req}, 0);
    wr_op(12'h108, 2, 32'hFFFF_FDFF, b, q); chk("R6 no bit9", {31'b0, q}, 0);
    wr_op(12'h109, 0, 32'h0000_0200, b, q); chk("R6 byte lane1", {31'b0, q}, 1);
    wr_op(12'h108, 0, 32'h0000_0200, b, q); chk("R6 lane0 masks bit9", {31'b0, q}, 0);
    wr_op(12'h10C, 2, 32'h0000_0200, b, q); chk("R6 other reg", {31'b0, q}, 0);
    rd_chk("R5 swrst rd", 12'h108, 2);
    // R8 ident writes ignored
    for (int a = 12'hFD0; a < 4096; a += 4) begin
      wr_op(a[11:0], 2, 32'hFFFF_FFFF, b, q);
      rd_chk("R8 ident", a[11:0], 2);
    end
    // R9 sub-word reads and writes over all lanes
    wr_op(12'h118, 2, 32'h1122_3344, b, q);
    for (int sz = 0; sz < 2; sz++)
      for (int lo = 0; lo < 4; lo++) rd_chk("R9 read lanes", 12'h118 + lo, sz[1:0]);
    for (int lo = 0; lo < 4; lo++) begin
      wr_op(12'h120 + lo, 0, 32'hDEAD_BEEF, b, q); rd_chk("R9 byte write", 12'h120, 2);
      wr_op(12'h104 + lo, 1, 32'hCAFE_F00D, b, q); rd_chk("R9 half write", 12'h104, 2);
    end
    // R10 unmapped writes: flag, then whole window unchanged
    for (int a = 0; a < 4096; a += 4)
      if (!is_mapped(a[11:0])) begin
        wr_op(a[11:0], 2, 32'hFFFF_FFFF, b, q);
        chk("R10 write flag", {31'b0, b}, 1);
      end
    for (int a = 0; a < 4096; a += 4) rd_chk("R10 no effect", a[11:0], 2);
    // R11 system reset keeps retention, power-on clears it
    foreach (regs_rw[i]) wr_op(regs_rw[i], 2, 32'h5A5A_0000 + i, b, q);
    wr_op(12'h004, 2, 32'h0000_FFFF, b, q);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; model_reset(0);
    foreach (regs_rw[i]) rd_chk("R11 sys reset", regs_rw[i], 2);
    rd_chk("R11 stat cleared", 12'h000, 2);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1; model_reset(1);
    rd_chk("R11 por retention", 12'h10C, 2);
    rd_chk("R1 cause after por", 12'h100, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule